// File: doc/BRIEF.md
# Disk DMA Channel Command and Status Registers

This block holds the command and status registers that software uses to run one bus-master disk DMA channel. Software reaches them with byte-wide writes and combinational reads at two offsets. Writing the command register's start bit from 0 to 1 sends a single-cycle start pulse to the DMA engine and marks the channel active. The pulse is sent only when the bus-master enable from configuration space is high. If software clears the start bit while the channel is still active and the drive has not yet interrupted, the block reports an abort.

The engine reports three kinds of event: a descriptor has finished (with or without its interrupt flag), the drive has interrupted, and the transfer is complete. The block folds these into sticky status bits. The two interrupt bits are cleared by writing 1 to them, and together they drive one interrupt line. The status register also holds two general-purpose capability flags, which the hardware never uses.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, reads at the command offset (00h) and the status offset (02h) return 00h. startPulse, abortPulse, irq, dmaRun and xferToMem are all low.
- R2: A command write that moves bit 0 (start) from 0 to 1 while busMasterEn is high raises startPulse for exactly one cycle, in the cycle after the write. In that same cycle, status bit 0 (active) reads 1.
- R3: Writing 1 to the start bit while it is already 1 produces no startPulse and changes nothing in the active bit.
- R4: If the start bit is written from 0 to 1 while busMasterEn is low, the start bit reads back 1 but no startPulse is produced and active stays 0.
- R5: A command write with start = 0, made while start is 1, active is 1 and status bit 2 is 0, raises abortPulse for one cycle in the cycle after the write and clears active. When status bit 2 is 1, the same write produces no abortPulse and leaves active as it was.
- R6: A one-cycle xferDone clears active in the next cycle. The hardware never clears the start bit; only a command write changes it.
- R7: Status bit 3 (descriptor interrupt) sets when prdDone and prdIrqFlag are high together. prdDone without the flag leaves it unchanged. A status write with bit 3 = 1 clears it, and if a set and a clear arrive in the same cycle, the set wins.
- R8: Status bit 2 (drive interrupt) sets on driveIrq and is cleared by a status write with bit 2 = 1. If both arrive in the same cycle, the set wins.
- R9: irq is high exactly when status bit 2 or status bit 3 is 1.
- R10: Status bits 5 and 6 are read/write flags that hold the value last written. They have no effect on any output.
- R11: Command bit 3 is read/write and drives xferToMem, where 1 means the transfer writes to memory. Command bits 1, 2 and 4 to 7, status bits 1, 4 and 7, and reads at any other offset return 0. Writes to these bits are ignored.
- R12: dmaRun is high exactly when both the start bit and the active bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| busMasterEn | input | 1 | Bus-master enable from configuration space |
| prdDone | input | 1 | Descriptor completed (one-cycle pulse) |
| prdIrqFlag | input | 1 | The completed descriptor carries an interrupt flag |
| driveIrq | input | 1 | Drive interrupt event |
| xferDone | input | 1 | Transfer finished event |
| startPulse | output | 1 | One-cycle start request to the DMA engine |
| abortPulse | output | 1 | One-cycle abort indication |
| dmaRun | output | 1 | Channel is started and active |
| xferToMem | output | 1 | Transfer direction: 1 = write to memory |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume no more than a clean reset and a synchronous, single-beat write port. They reason about why active rose or fell and why descriptor status fell, so an event input held high for several cycles is tolerated. The stimulus drives engine events and writes as one-cycle pulses, set up on the falling edge. In a few deliberate cycles it makes a set and a write-1-to-clear collide, and it toggles busMasterEn only between writes. The reference model applies every same-cycle priority explicitly: set over clear, and start over completion.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic cmdWr;
    logic stsWr;
    logic startEdge;
    logic abortHit;
  } regStrobe_t;

  // Bit positions inside the byte registers
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_DRV   = 2;
  localparam int STS_PRD   = 3;
  localparam int STS_CAP0  = 5;
  localparam int STS_CAP1  = 6;
endpackage

// File: rtl/dmaregs_ctrl.sv
module dmaregs_ctrl
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int CMD_OFS = 0,
  parameter int STS_OFS = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busMasterEn,
  input  logic              startQ,
  input  logic              activeQ,
  input  logic              drvIrqQ,
  output regStrobe_t        strobe,
  output logic              startPulse,
  output logic              abortPulse
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  always_comb begin
    strobe.cmdWr     = regWrEn && (regAddr == CMD_A);
    strobe.stsWr     = regWrEn && (regAddr == STS_A);
    // qualified rising edge of the start bit
    strobe.startEdge = strobe.cmdWr && regWrData[CMD_START] && !startQ && busMasterEn;
    // stop while a transfer is in flight and the drive has not finished
    strobe.abortHit  = strobe.cmdWr && !regWrData[CMD_START] && startQ && activeQ && !drvIrqQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      startPulse <= strobe.startEdge;
      abortPulse <= strobe.abortHit;
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(busMasterEn));
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(!startQ));
  assert_abort_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && abortPulse));
endmodule

// File: rtl/dmaregs_dp.sv
module dmaregs_dp
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int CMD_OFS = 0,
  parameter int STS_OFS = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              prdDone,
  input  logic              prdIrqFlag,
  input  logic              driveIrq,
  input  logic              xferDone,
  output logic [DATA_W-1:0] regRdData,
  output logic              startQ,
  output logic              activeQ,
  output logic              drvIrqQ,
  output logic              dmaRun,
  output logic              xferToMem,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  logic       dirQ;
  logic       prdQ;
  logic [1:0] capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      dirQ    <= 1'b0;
      activeQ <= 1'b0;
      drvIrqQ <= 1'b0;
      prdQ    <= 1'b0;
      capQ    <= '0;
    end else begin
      if (strobe.cmdWr) begin
        startQ <= regWrData[CMD_START];
        dirQ   <= regWrData[CMD_DIR];
      end
      // start has priority over completion
      if (strobe.startEdge)                   activeQ <= 1'b1;
      else if (xferDone || strobe.abortHit)   activeQ <= 1'b0;
      // set wins over write-1-to-clear
      if (driveIrq)                                    drvIrqQ <= 1'b1;
      else if (strobe.stsWr && regWrData[STS_DRV])     drvIrqQ <= 1'b0;
      if (prdDone && prdIrqFlag)                       prdQ <= 1'b1;
      else if (strobe.stsWr && regWrData[STS_PRD])     prdQ <= 1'b0;
      if (strobe.stsWr) capQ <= {regWrData[STS_CAP1], regWrData[STS_CAP0]};
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CMD_A) begin
      regRdData[CMD_START] = startQ;
      regRdData[CMD_DIR]   = dirQ;
    end else if (regAddr == STS_A) begin
      regRdData[STS_ACT]  = activeQ;
      regRdData[STS_DRV]  = drvIrqQ;
      regRdData[STS_PRD]  = prdQ;
      regRdData[STS_CAP0] = capQ[0];
      regRdData[STS_CAP1] = capQ[1];
    end
  end

  assign dmaRun    = startQ && activeQ;
  assign xferToMem = dirQ;
  assign irq       = drvIrqQ || prdQ;

  assert_active_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeQ) |-> $past(strobe.startEdge));
  assert_active_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> $past(xferDone || strobe.abortHit));
  assert_start_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startQ) |-> $past(strobe.cmdWr));
  assert_prd_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(prdQ) |-> $past(strobe.stsWr && regWrData[STS_PRD]));
  assert_drv_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drvIrqQ) |-> $past(strobe.stsWr && regWrData[STS_DRV]));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int CMD_OFS = 0,
  parameter int STS_OFS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              busMasterEn,
  input  logic              prdDone,
  input  logic              prdIrqFlag,
  input  logic              driveIrq,
  input  logic              xferDone,
  output logic              startPulse,
  output logic              abortPulse,
  output logic              dmaRun,
  output logic              xferToMem,
  output logic              irq
);
  localparam int DATA_W = 8;

  regStrobe_t strobe;
  logic       startQ;
  logic       activeQ;
  logic       drvIrqQ;

  dmaregs_ctrl #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STS_OFS(STS_OFS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .busMasterEn(busMasterEn), .startQ(startQ), .activeQ(activeQ), .drvIrqQ(drvIrqQ),
    .strobe(strobe), .startPulse(startPulse), .abortPulse(abortPulse)
  );

  dmaregs_dp #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STS_OFS(STS_OFS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr), .regWrData(regWrData),
    .prdDone(prdDone), .prdIrqFlag(prdIrqFlag), .driveIrq(driveIrq), .xferDone(xferDone),
    .regRdData(regRdData), .startQ(startQ), .activeQ(activeQ), .drvIrqQ(drvIrqQ),
    .dmaRun(dmaRun), .xferToMem(xferToMem), .irq(irq)
  );
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       busMasterEn = 1'b1;
  logic       prdDone = 1'b0, prdIrqFlag = 1'b0, driveIrq = 1'b0, xferDone = 1'b0;
  logic       startPulse, abortPulse, dmaRun, xferToMem, irq;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  bit mStart, mDir, mAct, mDrv, mPrd, mSP, mAP;
  bit [1:0] mCap;

  dma_chan_regs u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .busMasterEn(busMasterEn), .prdDone(prdDone),
    .prdIrqFlag(prdIrqFlag), .driveIrq(driveIrq), .xferDone(xferDone),
    .startPulse(startPulse), .abortPulse(abortPulse), .dmaRun(dmaRun),
    .xferToMem(xferToMem), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic bit [7:0] modelRead(input bit [1:0] a);
    if (a == 2'd0) return {4'b0, mDir, 2'b0, mStart};
    if (a == 2'd2) return {1'b0, mCap[1], mCap[0], 1'b0, mPrd, mDrv, 1'b0, mAct};
    return 8'h00;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit cw, sw, nSP, nAP;
    if (!rstN) begin
      {mStart, mDir, mAct, mDrv, mPrd, mSP, mAP} = '0;
      mCap = '0;
    end else begin
      cw  = regWrEn && regAddr == 2'd0;
      sw  = regWrEn && regAddr == 2'd2;
      nSP = cw && regWrData[0] && !mStart && busMasterEn;
      nAP = cw && !regWrData[0] && mStart && mAct && !mDrv;
      if (nSP) mAct = 1'b1;
      else if (xferDone || nAP) mAct = 1'b0;
      if (driveIrq) mDrv = 1'b1;
      else if (sw && regWrData[2]) mDrv = 1'b0;
      if (prdDone && prdIrqFlag) mPrd = 1'b1;
      else if (sw && regWrData[3]) mPrd = 1'b0;
      if (sw) mCap = regWrData[6:5];
      if (cw) begin mStart = regWrData[0]; mDir = regWrData[3]; end
      mSP = nSP;
      mAP = nAP;
    end
    #2;
    chk("regRdData", regRdData, modelRead(regAddr));
    chk("startPulse R2", startPulse, mSP);
    chk("abortPulse R5", abortPulse, mAP);
    chk("irq R9", irq, mDrv | mPrd);
    chk("dmaRun R12", dmaRun, mStart & mAct);
    chk("xferToMem R11", xferToMem, mDir);
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic look(input bit [1:0] a, input int n);
    @(negedge clk); regAddr = a;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ev(input bit pd, input bit pf, input bit di, input bit xd);
    @(negedge clk); prdDone = pd; prdIrqFlag = pf; driveIrq = di; xferDone = xd;
    @(negedge clk); {prdDone, prdIrqFlag, driveIrq, xferDone} = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    look(2'd0, 2); look(2'd2, 2);

    curReq = "R10";
    wr(2'd2, 8'h60); look(2'd2, 1); look(2'd0, 1);
    wr(2'd2, 8'h20); look(2'd2, 1);
    curReq = "R11";
    wr(2'd2, 8'hFF); look(2'd2, 1);
    wr(2'd0, 8'hF6); look(2'd0, 1); look(2'd1, 1); look(2'd3, 1);
    wr(2'd2, 8'h00);

    curReq = "R4";
    busMasterEn = 1'b0;
    wr(2'd0, 8'h01); look(2'd2, 2);
    busMasterEn = 1'b1;
    curReq = "R3";
    wr(2'd0, 8'h01); look(2'd2, 2);
    wr(2'd0, 8'h00);
    curReq = "R2";
    wr(2'd0, 8'h09); look(2'd2, 2);
    curReq = "R3";
    wr(2'd0, 8'h09); look(2'd0, 2);

    curReq = "R6";
    ev(0, 0, 0, 1); look(2'd2, 2); look(2'd0, 1);

    curReq = "R8";
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    ev(0, 0, 1, 0); look(2'd2, 1);
    curReq = "R5";
    wr(2'd0, 8'h00); look(2'd2, 2);
    curReq = "R8";
    wr(2'd2, 8'h04); look(2'd2, 1);
    curReq = "R5";
    ev(0, 0, 0, 1);
    wr(2'd0, 8'h01); look(2'd2, 1);
    wr(2'd0, 8'h00); look(2'd2, 2);

    curReq = "R7";
    ev(1, 0, 0, 0); look(2'd2, 1);
    ev(1, 1, 0, 0); look(2'd2, 1);
    wr(2'd2, 8'h04); look(2'd2, 1);
    wr(2'd2, 8'h08); look(2'd2, 1);
    ev(1, 1, 0, 0);
    @(negedge clk); regAddr = 2'd2; regWrData = 8'h08; regWrEn = 1'b1; prdDone = 1'b1; prdIrqFlag = 1'b1;
    @(negedge clk); regWrEn = 1'b0; prdDone = 1'b0; prdIrqFlag = 1'b0;
    look(2'd2, 1);
    curReq = "R8";
    @(negedge clk); regAddr = 2'd2; regWrData = 8'h04; regWrEn = 1'b1; driveIrq = 1'b1;
    @(negedge clk); regWrEn = 1'b0; driveIrq = 1'b0;
    look(2'd2, 1);
    curReq = "R9";
    wr(2'd2, 8'h08); look(2'd2, 1);
    wr(2'd2, 8'h04); look(2'd2, 2);

    curReq = "R12";
    wr(2'd0, 8'h01); look(2'd0, 2);
    ev(0, 0, 0, 1); look(2'd0, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule